// File: doc/BRIEF.md
# PWM Output Pin Steering with Synchronised Update

This block takes one PWM waveform and routes it to any subset of a small group of output pins. The default is four pins. A steering word holds one enable bit per pin. An enabled pin carries the live PWM signal. A disabled pin drives a fixed inactive level that is set by a block-wide polarity input.

Software writes a new steering word with a one-cycle write strobe. The sync-mode bit that comes with the write decides when the new word takes effect:

- **Immediate mode (sync bit 0).** The word is applied at the clock edge that ends the write cycle. A pulse on a pin may be cut short.
- **Synchronised mode (sync bit 1).** The word waits in a pending register and is applied on the next period-start strobe from the PWM timer. Pins are then switched only at period boundaries, so only whole pulses reach them.

Top module: `pwm_steer`

## Requirements
- R1: While reset is active, and after it is released with no write, the applied steering word is all zeros and every pin drives the idle level.
- R2: A pin whose applied steering bit (bit i for pin i) is 1 drives the PWM input in the same cycle, with no register in the path.
- R3: A pin whose applied steering bit is 0 drives the idle-level input.
- R4: A write with sync bit 0 changes the applied word to the written data at the clock edge that ends the write cycle. The change is visible on the pins in the next cycle.
- R5: A write with sync bit 1 leaves the applied word unchanged until a period-start strobe arrives. At the edge that ends the strobe cycle, the pending word becomes the applied word.
- R6: If two or more synchronised writes arrive before a period start, only the last written word is applied.
- R7: A synchronised write in the same cycle as a period-start strobe is applied at that same edge.
- R8: An immediate write discards any pending synchronised word. A later period start then leaves the applied word unchanged.
- R9: A period-start strobe with nothing pending leaves the applied word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pwm_in | input | 1 | Raw PWM waveform |
| period_start | input | 1 | Single-cycle strobe at the start of each PWM period |
| wr_en | input | 1 | Steering register write strobe |
| wr_data | input | PINS | New steering word, one enable bit per pin |
| sync_mode | input | 1 | Mode of this write: 0 immediate, 1 at next period start |
| idle_level | input | 1 | Level driven on pins that are steered off |
| pin_out | output | PINS | Steered output pins |

## Verification
The main collision is a synchronised write that lands in the same cycle as a period-start strobe. The write must be applied at once, and any older pending word must be dropped. The second collision is an immediate write that overrides a word still pending. The bench provokes both with directed sequences, then mixes random writes, modes, strobes and idle levels. Every cycle it compares the pins against a reference model in the bench that follows the stated precedence.

// File: rtl/pwm_steer_pkg.sv
package pwm_steer_pkg;

    // Source chosen for the next applied steering word
    typedef enum logic [1:0] {
        UPD_NONE     = 2'd0,
        UPD_NOW      = 2'd1,
        UPD_BOUNDARY = 2'd2
    } upd_src_e;

endpackage

// File: rtl/steer_pending.sv
module steer_pending #(
    parameter int unsigned PINS = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [PINS-1:0] wr_data,
    input  logic            sync_mode,
    input  logic            period_start,
    output logic [PINS-1:0] pend_data,
    output logic            pend_valid
);

    typedef struct packed {
        logic [PINS-1:0] data;
        logic            valid;
    } pend_t;

    pend_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en && !sync_mode) begin
            st_d.valid = 1'b0;               // immediate write drops any pending word
        end else if (wr_en && sync_mode && !period_start) begin
            st_d.data  = wr_data;            // newest synchronised write wins
            st_d.valid = 1'b1;
        end else if (period_start) begin
            st_d.valid = 1'b0;               // consumed at the boundary
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend_data  = st_q.data;
    assign pend_valid = st_q.valid;

endmodule

// File: rtl/steer_apply.sv
module steer_apply
    import pwm_steer_pkg::*;
#(
    parameter int unsigned PINS = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [PINS-1:0] wr_data,
    input  logic            sync_mode,
    input  logic            period_start,
    input  logic [PINS-1:0] pend_data,
    input  logic            pend_valid,
    output logic [PINS-1:0] applied
);

    typedef struct packed {
        logic [PINS-1:0] steer;
    } apply_t;

    apply_t   st_d, st_q;
    upd_src_e src;
    logic [PINS-1:0] src_word;

    always_comb begin
        src      = UPD_NONE;
        src_word = st_q.steer;
        if (wr_en && !sync_mode) begin
            src      = UPD_NOW;
            src_word = wr_data;
        end else if (period_start && wr_en && sync_mode) begin
            src      = UPD_BOUNDARY;
            src_word = wr_data;
        end else if (period_start && pend_valid) begin
            src      = UPD_BOUNDARY;
            src_word = pend_data;
        end
    end

    always_comb begin
        st_d = st_q;
        case (src)
            UPD_NOW, UPD_BOUNDARY: st_d.steer = src_word;
            default:               st_d = st_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign applied = st_q.steer;

endmodule

// File: rtl/steer_pinmux.sv
module steer_pinmux #(
    parameter int unsigned PINS = 4
) (
    input  logic [PINS-1:0] applied,
    input  logic            pwm_in,
    input  logic            idle_level,
    output logic [PINS-1:0] pin_out
);

    for (genvar gi = 0; gi < PINS; gi++) begin : g_pin
        always_comb begin
            pin_out[gi] = applied[gi] ? pwm_in : idle_level;
        end
    end

endmodule

// File: rtl/pwm_steer.sv
module pwm_steer #(
    parameter int unsigned PINS = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            pwm_in,
    input  logic            period_start,
    input  logic            wr_en,
    input  logic [PINS-1:0] wr_data,
    input  logic            sync_mode,
    input  logic            idle_level,
    output logic [PINS-1:0] pin_out
);

    logic [PINS-1:0] pend_data;
    logic            pend_valid;
    logic [PINS-1:0] applied;

    steer_pending #(.PINS(PINS)) u_pending (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (wr_en),
        .wr_data      (wr_data),
        .sync_mode    (sync_mode),
        .period_start (period_start),
        .pend_data    (pend_data),
        .pend_valid   (pend_valid)
    );

    steer_apply #(.PINS(PINS)) u_apply (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (wr_en),
        .wr_data      (wr_data),
        .sync_mode    (sync_mode),
        .period_start (period_start),
        .pend_data    (pend_data),
        .pend_valid   (pend_valid),
        .applied      (applied)
    );

    steer_pinmux #(.PINS(PINS)) u_mux (
        .applied    (applied),
        .pwm_in     (pwm_in),
        .idle_level (idle_level),
        .pin_out    (pin_out)
    );

endmodule

// File: rtl/pwm_steer_chk.sv
module pwm_steer_chk #(
    parameter int unsigned PINS = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            pwm_in,
    input logic            period_start,
    input logic            wr_en,
    input logic [PINS-1:0] wr_data,
    input logic            sync_mode,
    input logic            idle_level,
    input logic [PINS-1:0] applied,
    input logic            pend_valid,
    input logic [PINS-1:0] pin_out
);

    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> (applied == '0 || !rst_n)) else $error("reset"); // R1

    AST_PIN_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
        pin_out == ((applied & {PINS{pwm_in}}) | (~applied & {PINS{idle_level}})))
        else $error("route"); // R2

    AST_IMM_APPLY: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !sync_mode) |=> applied == $past(wr_data)) else $error("imm"); // R4

    AST_HOLD_NO_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        (!period_start && !(wr_en && !sync_mode)) |=> $stable(applied)) else $error("hold"); // R5

    AST_SAME_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sync_mode && period_start) |=> applied == $past(wr_data)) else $error("same"); // R7

    AST_CANCEL_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !sync_mode) |=> !pend_valid) else $error("cancel"); // R8

    AST_IDLE_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        (period_start && !pend_valid && !wr_en) |=> $stable(applied)) else $error("idle"); // R9

endmodule

bind pwm_steer pwm_steer_chk #(.PINS(PINS)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .pwm_in       (pwm_in),
    .period_start (period_start),
    .wr_en        (wr_en),
    .wr_data      (wr_data),
    .sync_mode    (sync_mode),
    .idle_level   (idle_level),
    .applied      (applied),
    .pend_valid   (pend_valid),
    .pin_out      (pin_out)
);

// File: tb/pwm_steer_tb.sv
module pwm_steer_tb;

    localparam int unsigned PINS = 4;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            pwm_in = 1'b0;
    logic            period_start = 1'b0;
    logic            wr_en = 1'b0;
    logic [PINS-1:0] wr_data = '0;
    logic            sync_mode = 1'b0;
    logic            idle_level = 1'b0;
    logic [PINS-1:0] pin_out;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    // reference state
    logic [PINS-1:0] m_app = '0;
    logic [PINS-1:0] m_pend = '0;
    logic            m_pv = 1'b0;
    string           tag = "R1";

    always #4 clk = ~clk;   // 125 MHz

    pwm_steer #(.PINS(PINS)) u_dut (
        .clk(clk), .rst_n(rst_n), .pwm_in(pwm_in), .period_start(period_start),
        .wr_en(wr_en), .wr_data(wr_data), .sync_mode(sync_mode),
        .idle_level(idle_level), .pin_out(pin_out)
    );

    function automatic logic [PINS-1:0] exp_pins(logic [PINS-1:0] app, logic p, logic idl);
        logic [PINS-1:0] r;
        for (int i = 0; i < PINS; i++) r[i] = app[i] ? p : idl;
        return r;
    endfunction

    task automatic check_pins(string t);
        logic [PINS-1:0] e;
        e = exp_pins(m_app, pwm_in, idle_level);
        total++;
        if (pin_out !== e) begin
            bad++;
            $display("FAIL %s pin_out=%b expected=%b", t, pin_out, e);
        end
    endtask

    // Model update following R4..R9 precedence
    task automatic model_step();
        if (wr_en && !sync_mode) begin
            m_app = wr_data; m_pv = 1'b0; tag = "R4";
        end else if (wr_en && sync_mode && period_start) begin
            m_app = wr_data; m_pv = 1'b0; tag = "R7";
        end else if (wr_en && sync_mode) begin
            m_pend = wr_data; m_pv = 1'b1; tag = "R5";
        end else if (period_start) begin
            if (m_pv) begin m_app = m_pend; tag = "R6"; end
            else tag = "R9";
            m_pv = 1'b0;
        end
    endtask

    // One cycle: drive at negedge, check combinational pins, then the edge updates state
    task automatic cycle(logic we, logic [PINS-1:0] d, logic sm, logic ps, logic p, logic idl);
        @(negedge clk);
        wr_en = we; wr_data = d; sync_mode = sm; period_start = ps;
        pwm_in = p; idle_level = idl;
        #1;
        check_pins(tag);
        model_step();
    endtask

    initial begin
        #2000000;
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int unsigned seed;
        seed = 32'd1234;
        void'($urandom(seed));
        // R1: reset state, both idle levels
        @(negedge clk); idle_level = 1'b1; pwm_in = 1'b0; #1; check_pins("R1");
        @(negedge clk); idle_level = 1'b0; pwm_in = 1'b1; #1; check_pins("R1");
        @(negedge clk); rst_n = 1'b1;
        cycle(0, '0, 0, 1, 1, 1);                 // R1 after release, R9 strobe
        // R4 immediate then R2/R3 with toggling pwm
        cycle(1, 4'b0101, 0, 0, 1, 0);
        cycle(0, '0, 0, 0, 1, 0); tag = "R2";
        cycle(0, '0, 0, 0, 0, 1); tag = "R3";
        // R5/R6 two sync writes, hold, then boundary
        cycle(1, 4'b1000, 1, 0, 1, 0);
        cycle(1, 4'b0011, 1, 0, 1, 0);
        cycle(0, '0, 0, 0, 1, 0); tag = "R5";
        cycle(0, '0, 0, 1, 1, 0);
        cycle(0, '0, 0, 0, 1, 1); tag = "R6";
        // R7 same-cycle collision with an older pending word
        cycle(1, 4'b1111, 1, 0, 1, 0);
        cycle(1, 4'b1010, 1, 1, 1, 0);
        cycle(0, '0, 0, 0, 1, 0); tag = "R7";
        cycle(0, '0, 0, 1, 1, 0); tag = "R9";
        // R8 immediate write cancels pending
        cycle(1, 4'b0110, 1, 0, 1, 0);
        cycle(1, 4'b0001, 0, 0, 1, 0);
        cycle(0, '0, 0, 1, 1, 0); tag = "R8";
        cycle(0, '0, 0, 0, 1, 1); tag = "R8";
        // random mix
        for (int n = 0; n < 3000; n++) begin
            cycle(($urandom % 4) == 0, PINS'($urandom), $urandom % 2,
                  ($urandom % 6) == 0, $urandom % 2, ($urandom % 16) == 0);
        end
        cycle(0, '0, 0, 0, 1, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule